// File: doc/BRIEF.md
# DMA Command Completion Counter

This block sits beside one channel of a list-driven DMA engine and tells software how far the engine has got. Each time the transfer engine reports an event, the block advances a 6-bit done count. The first event of a command list says that the list was loaded, and each later event says that one command finished. The block does not tell these apart, so every event advances the count in the same way.

Software acknowledges by writing back the done value it last read into a separate processed field. The block compares the two counts, both modulo 64. While they differ and interrupts are enabled, the block reports a pending interrupt. A done event that arrives between the software read and its acknowledging write therefore leaves the counts unequal, and the interrupt stays up.

Access goes through a 32-bit register port with two words: a configuration word at address 0 and a status word at address 1. The interrupt output is active high. It can either follow the pending condition as a level or give a single-cycle pulse for each new event.

Top module: `cmpl_counter_top`

## Requirements
- R1: After reset, the status word, the configuration word and `irq` are all zero.
- R2: Each cycle in which `evt_pulse` is high advances the done count in status bits 5:0 by exactly one, modulo 64. The first event after a list starts, which marks the list as loaded, advances the count the same way.
- R3: A write to address 1 loads the processed count in status bits 21:16 from the write data. The done field and bit 8 of the write data have no effect on the stored done count.
- R4: When an event and a status write land in the same cycle, the done count still advances and the processed count takes the written value. The interrupt stays pending if the two counts now differ.
- R5: Status bit 8 (interrupt active) reads 1 exactly when configuration bits 31 (list interrupt enable) and 29 (interrupt enable) are both 1 and the done count differs from the processed count.
- R6: With configuration bit 28 (level mode) set, `irq` equals the interrupt-active condition and stays high until software acknowledges.
- R7: With level mode clear, `irq` is high for the single cycle that follows an event, and only if after that event both enables are set and the counts differ.
- R8: The configuration word stores bits 31, 29 and 28. All other bits read 0.
- R9: Addresses other than 0 and 1 read 0, and writes to them change nothing.
- R10: Both counts wrap modulo 64. If software has acknowledged and exactly 64 more events then arrive, the counts are equal again and no interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Word address: 0 configuration, 1 status |
| reg_wr_en | input | 1 | Write strobe for the addressed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word |
| evt_pulse | input | 1 | One pulse per list-loaded or command-completed event |
| irq | output | 1 | Active-high interrupt request |

## Verification
The hardest case to reach is the race in which software acknowledges in the same cycle that a new event arrives. The bench drives the event pulse and the status write on the same falling clock edge, so both reach the same rising edge. It then checks that the done count moved past the acknowledged value and that the interrupt is still high. The modulo-64 blind spot is reached by holding the event input high for 64 consecutive cycles after an acknowledge, and then checking that the interrupt is quiet. The pulse mode is checked cycle by cycle around a single event.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;

    localparam int REG_W      = 32;
    localparam int MAX_CNT_W  = 8;

    // status word layout, decoded by software
    localparam int DONE_LSB   = 0;
    localparam int ACTIVE_BIT = 8;
    localparam int PROC_LSB   = 16;

    // configuration word layout
    localparam int CFG_LIST_IEN_BIT = 31;
    localparam int CFG_IEN_BIT      = 29;
    localparam int CFG_LEVEL_BIT    = 28;

    // word addresses
    localparam int ADDR_CFG  = 0;
    localparam int ADDR_STAT = 1;

    typedef struct packed {
        logic list_ien;
        logic ien;
        logic level;
    } irq_cfg_t;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_NONE = 2'd2
    } reg_sel_e;

    function automatic irq_cfg_t cfg_from_word(input logic [REG_W-1:0] w);
        irq_cfg_t c;
        c.list_ien = w[CFG_LIST_IEN_BIT];
        c.ien      = w[CFG_IEN_BIT];
        c.level    = w[CFG_LEVEL_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_to_word(input irq_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[CFG_LIST_IEN_BIT] = c.list_ien;
        w[CFG_IEN_BIT]      = c.ien;
        w[CFG_LEVEL_BIT]    = c.level;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] status_word(
        input logic [MAX_CNT_W-1:0] done_v,
        input logic [MAX_CNT_W-1:0] proc_v,
        input logic                 active
    );
        logic [REG_W-1:0] w;
        w = '0;
        w[DONE_LSB +: MAX_CNT_W] = done_v;
        w[PROC_LSB +: MAX_CNT_W] = proc_v;
        w[ACTIVE_BIT]            = active;
        return w;
    endfunction

endpackage

// File: rtl/cmpl_cfg_reg.sv
module cmpl_cfg_reg
    import cmpl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output irq_cfg_t         cfg
);

    irq_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= cfg_from_word(wdata);
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/cmpl_counts.sv
module cmpl_counts #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             ack_wr,
    input  logic [CNT_W-1:0] ack_val,
    output logic [CNT_W-1:0] done_cnt,
    output logic [CNT_W-1:0] proc_cnt,
    output logic             evt_seen
);

    logic [CNT_W-1:0] done_q;
    logic [CNT_W-1:0] proc_q;
    logic             seen_q;
    logic [CNT_W-1:0] done_nxt;

    // the done count only ever moves by events; register writes never touch it
    always_comb begin
        done_nxt = done_q;
        if (evt) begin
            done_nxt = done_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= '0;
            proc_q <= '0;
            seen_q <= 1'b0;
        end else begin
            done_q <= done_nxt;
            seen_q <= evt;
            if (ack_wr) begin
                proc_q <= ack_val;
            end
        end
    end

    assign done_cnt = done_q;
    assign proc_cnt = proc_q;
    assign evt_seen = seen_q;

endmodule

// File: rtl/cmpl_irq_gen.sv
module cmpl_irq_gen
    import cmpl_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  irq_cfg_t         cfg,
    input  logic [CNT_W-1:0] done_cnt,
    input  logic [CNT_W-1:0] proc_cnt,
    input  logic             evt_seen,
    output logic             pending,
    output logic             irq
);

    logic enabled;
    logic differ;

    assign enabled = cfg.list_ien & cfg.ien;
    assign differ  = (done_cnt != proc_cnt);
    assign pending = enabled & differ;

    always_comb begin
        if (cfg.level) begin
            irq = pending;
        end else begin
            irq = pending & evt_seen;
        end
    end

endmodule

// File: rtl/cmpl_counter_top.sv
module cmpl_counter_top
    import cmpl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              evt_pulse,
    output logic              irq
);

    reg_sel_e         sel;
    logic             cfg_wr;
    logic             stat_wr;
    logic [CNT_W-1:0] ack_val;
    irq_cfg_t         cfg;
    logic [CNT_W-1:0] done_cnt;
    logic [CNT_W-1:0] proc_cnt;
    logic             evt_seen;
    logic             pending;

    always_comb begin
        if (reg_addr == ADDR_W'(ADDR_CFG)) begin
            sel = SEL_CFG;
        end else if (reg_addr == ADDR_W'(ADDR_STAT)) begin
            sel = SEL_STAT;
        end else begin
            sel = SEL_NONE;
        end
    end

    assign cfg_wr  = reg_wr_en & (sel == SEL_CFG);
    assign stat_wr = reg_wr_en & (sel == SEL_STAT);
    assign ack_val = reg_wdata[PROC_LSB +: CNT_W];

    cmpl_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_wr),
        .wdata (reg_wdata),
        .cfg   (cfg)
    );

    cmpl_counts #(.CNT_W(CNT_W)) u_counts (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_pulse),
        .ack_wr   (stat_wr),
        .ack_val  (ack_val),
        .done_cnt (done_cnt),
        .proc_cnt (proc_cnt),
        .evt_seen (evt_seen)
    );

    cmpl_irq_gen #(.CNT_W(CNT_W)) u_irq (
        .cfg      (cfg),
        .done_cnt (done_cnt),
        .proc_cnt (proc_cnt),
        .evt_seen (evt_seen),
        .pending  (pending),
        .irq      (irq)
    );

    always_comb begin
        case (sel)
            SEL_CFG:  reg_rdata = cfg_to_word(cfg);
            SEL_STAT: reg_rdata = status_word(MAX_CNT_W'(done_cnt),
                                              MAX_CNT_W'(proc_cnt), pending);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cmpl_counter_chk.sv
module cmpl_counter_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             evt,
    input logic             stat_wr,
    input logic [CNT_W-1:0] wr_proc,
    input logic [CNT_W-1:0] done_cnt,
    input logic [CNT_W-1:0] proc_cnt,
    input logic             level,
    input logic             both_en,
    input logic             irq
);

    assert_done_step_R2: assert property (@(posedge clk) disable iff (rst)
        evt |=> done_cnt == $past(done_cnt) + CNT_W'(1));

    assert_done_untouched_R3: assert property (@(posedge clk) disable iff (rst)
        !evt |=> $stable(done_cnt));

    assert_proc_load_R3: assert property (@(posedge clk) disable iff (rst)
        stat_wr |=> proc_cnt == $past(wr_proc));

    assert_irq_needs_gap_R5: assert property (@(posedge clk) disable iff (rst)
        irq |-> (done_cnt != proc_cnt) && both_en);

    assert_level_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (level && both_en && (done_cnt != proc_cnt)) |-> irq);

    assert_pulse_after_evt_R7: assert property (@(posedge clk) disable iff (rst)
        (!level && irq) |-> $past(evt));

endmodule

bind cmpl_counter_top cmpl_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt_pulse),
    .stat_wr  (stat_wr),
    .wr_proc  (ack_val),
    .done_cnt (done_cnt),
    .proc_cnt (proc_cnt),
    .level    (cfg.level),
    .both_en  (pending | (cfg.list_ien & cfg.ien)),
    .irq      (irq)
);

// File: tb/cmpl_counter_top_test.sv
module cmpl_counter_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        evt_pulse = 1'b0;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cmpl_counter_top uut (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_pulse (evt_pulse),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic events(input int n);
        @(negedge clk);
        evt_pulse = 1'b1;
        repeat (n - 1) @(negedge clk);
        @(negedge clk);
        evt_pulse = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(4'd1, d); chk("R1 status", d, 32'h0);
        rd(4'd0, d); chk("R1 config", d, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_config;
        logic [31:0] d;
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, d); chk("R8 all ones", d, 32'hB000_0000);
        wr(4'd0, 32'h3000_0000);
        rd(4'd0, d); chk("R8 partial", d, 32'h3000_0000);
    endtask

    task automatic t_count;
        logic [31:0] d;
        wr(4'd0, 32'hB000_0000);
        events(1);                    // list-loaded event
        rd(4'd1, d); chk("R2 first event", d, 32'h0000_0101);
        chk("R6 level irq", {31'd0, irq}, 32'd1);
        events(2);
        rd(4'd1, d); chk("R2 three events", d, 32'h0000_0103);
    endtask

    task automatic t_ack;
        logic [31:0] d;
        wr(4'd1, 32'h0003_013F);      // junk in done field and bit 8
        rd(4'd1, d); chk("R3 ack", d, 32'h0003_0003);
        chk("R6 irq clear", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_enable;
        logic [31:0] d;
        wr(4'd0, 32'h3000_0000);      // list enable off
        events(1);
        rd(4'd1, d); chk("R5 gated", d, 32'h0003_0004);
        chk("R5 irq gated", {31'd0, irq}, 32'd0);
        wr(4'd0, 32'hB000_0000);
        rd(4'd1, d); chk("R5 enabled", d, 32'h0003_0104);
        chk("R6 irq enabled", {31'd0, irq}, 32'd1);
        wr(4'd1, 32'h0004_0000);
        rd(4'd1, d); chk("R3 ack2", d, 32'h0004_0004);
    endtask

    task automatic t_race;
        logic [31:0] d;
        events(1);                    // done = 5, software reads 5
        @(negedge clk);
        evt_pulse = 1'b1;
        reg_addr  = 4'd1;
        reg_wdata = 32'h0005_0000;
        reg_wr_en = 1'b1;
        @(negedge clk);
        evt_pulse = 1'b0;
        reg_wr_en = 1'b0;
        rd(4'd1, d); chk("R4 race status", d, 32'h0005_0106);
        chk("R4 race irq", {31'd0, irq}, 32'd1);
        wr(4'd1, 32'h0006_0000);
    endtask

    task automatic t_wrap;
        logic [31:0] d;
        events(64);
        rd(4'd1, d); chk("R10 full wrap", d, 32'h0006_0006);
        chk("R10 irq quiet", {31'd0, irq}, 32'd0);
        events(60);
        rd(4'd1, d); chk("R10 partial wrap", d, 32'h0006_0102);
        wr(4'd1, 32'h0002_0000);
    endtask

    task automatic t_pulse;
        logic [31:0] d;
        wr(4'd0, 32'hA000_0000);      // both enables, pulse mode
        @(negedge clk);
        evt_pulse = 1'b1;
        @(negedge clk);
        evt_pulse = 1'b0;
        chk("R7 pulse high", {31'd0, irq}, 32'd1);
        @(negedge clk);
        chk("R7 pulse one cycle", {31'd0, irq}, 32'd0);
        rd(4'd1, d); chk("R5 still active", d, 32'h0002_0103);
        wr(4'd1, 32'h0003_0000);
        wr(4'd0, 32'h0000_0000);
        @(negedge clk);
        evt_pulse = 1'b1;
        @(negedge clk);
        evt_pulse = 1'b0;
        chk("R7 no pulse disabled", {31'd0, irq}, 32'd0);
        rd(4'd1, d); chk("R5 disabled", d, 32'h0003_0004);
    endtask

    task automatic t_addr;
        logic [31:0] d;
        wr(4'd5, 32'hFFFF_FFFF);
        rd(4'd5, d); chk("R9 unused read", d, 32'h0);
        rd(4'd0, d); chk("R9 config kept", d, 32'h0);
        rd(4'd1, d); chk("R9 status kept", d, 32'h0003_0004);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_config;
        t_count;
        t_ack;
        t_enable;
        t_race;
        t_wrap;
        t_pulse;
        t_addr;
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule